// File: doc/BRIEF.md
# Receive Highway Serializer

This block takes the bytes of a received 32-slot frame and shifts them out as a serial stream on a system-side highway. The frame timing comes from a system receive clock that runs at 4096 kHz and from a system frame-sync input. Each time slot takes a window of 16 clocks, so a frame is always 512 clocks long. In single-rate mode (2048 kbit/s) each bit is held for two clocks and the highway is driven all the time. In double-rate mode (4096 kbit/s) each bit is held for one clock. A slot's eight bits then fill one half of its 16-clock window, and the output enable is low during the other half.

The block reads its bytes from a parallel source through a slot index it presents. The source must return the addressed byte combinationally. A frame-sync pulse, sampled on the rising clock edge, restarts the internal frame position. Time slot 0 then begins after a programmable delay built from three offset fields. Output data and enable are registered on the falling clock edge. Tri-state is represented by the separate enable output, and the data line idles high while that enable is low.

Top module: `hwy_rx_serializer`

## Requirements
- R1: After reset, and until the first frame-sync is sampled, `hwy_oe_o` is 0 and `hwy_data_o` is 1.
- R2: The frame position advances by one on each rising clock edge. `slot_idx_o` shows the slot (position divided by 16) whose byte is being serialized.
- R3: With `rate_i`=0 (single rate), `hwy_oe_o` is 1. Each bit of a slot byte is held for two clocks, most significant bit first, so bit 7 is in window clocks 0-1 and bit 0 is in clocks 14-15.
- R4: `hwy_data_o` and `hwy_oe_o` change only on the falling clock edge and stay unchanged across the rising edge.
- R5: If frame-sync is sampled high at rising edge E, bit 7 of slot 0 is presented on the falling edge after rising edge E+D. Here D = (16*`ts_off_i` + 2*`cs_off_i` + `half_sel_i`) mod 512.
- R6: With `rate_i`=1 (double rate), a slot's bits come out one per clock, MSB first. They fill window clocks 0-7 when `phase_sel_i`=0 and window clocks 8-15 when `phase_sel_i`=1.
- R7: In double rate, during the unselected half of each slot window, `hwy_oe_o` is 0 and `hwy_data_o` is 1.
- R8: Offset delays of 512 clocks or more wrap modulo the frame length. This applies, for example, to `ts_off_i` values of 32 to 63.
- R9: With no further frame-sync, the position wraps from 511 back to 0, and the next frame follows seamlessly.
- R10: A change of the offset inputs between frame-sync pulses has no effect on the output timing.
- R11: A frame-sync arriving at any position realigns the frame immediately, using the offsets present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System receive clock, 4096 kHz |
| rst_n | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | System frame-sync, sampled on the rising edge |
| rate_i | input | 1 | 0: 2048 kbit/s, 1: 4096 kbit/s |
| phase_sel_i | input | 1 | Half of the slot window used in double rate |
| ts_off_i | input | 6 | Time-slot offset, in whole slots |
| cs_off_i | input | 3 | Clock-slot offset, in single-rate bit periods |
| half_sel_i | input | 1 | Extra half single-rate bit (one clock) of delay |
| slot_idx_o | output | 5 | Slot index presented to the byte source |
| slot_byte_i | input | 8 | Byte of the addressed slot |
| hwy_data_o | output | 1 | Serial highway data |
| hwy_oe_o | output | 1 | Highway output enable (low = high impedance) |

## Verification
The checker watches several properties on every rising edge. It checks the position step and its wrap at the frame end, and the loaded position after a frame-sync against the offsets. It also checks that the enable stays low until the first sync and that data idles high whenever the enable is low. Only the bench scenarios can show that the right byte bits appear MSB first in the right half-window for both rates and phases. The same holds for where slot 0 lands for each offset mix, that offset changes between syncs are ignored, and that nothing on the output moves at the rising edge.

// File: rtl/hwy_rx_pkg.sv
`timescale 1ns/1ps
package hwy_rx_pkg;

    typedef enum logic {
        RATE_SINGLE = 1'b0,
        RATE_DOUBLE = 1'b1
    } hwy_rate_e;

    typedef struct packed {
        logic data;
        logic en;
    } hwy_out_t;

    localparam hwy_out_t HWY_IDLE = '{data: 1'b1, en: 1'b0};

endpackage

// File: rtl/hwy_rx_offset.sv
`timescale 1ns/1ps
module hwy_rx_offset #(
    parameter int TS_W         = 6,
    parameter int CS_W         = 3,
    parameter int CLK_PER_SLOT = 16,
    parameter int FRAME_CLKS   = 512,
    parameter int POS_W        = 9
) (
    input  logic [TS_W-1:0]  ts_off_i,
    input  logic [CS_W-1:0]  cs_off_i,
    input  logic             half_sel_i,
    output logic [POS_W-1:0] load_pos_o
);
    localparam int OFF_W = TS_W + $clog2(CLK_PER_SLOT) + 2;

    logic [OFF_W-1:0] delay_full;
    logic [OFF_W-1:0] delay_mod;
    logic [OFF_W-1:0] start_pos;

    always_comb begin
        delay_full = OFF_W'(ts_off_i) * OFF_W'(CLK_PER_SLOT)
                   + (OFF_W'(cs_off_i) << 1)
                   + OFF_W'(half_sel_i);
        delay_mod  = delay_full % OFF_W'(FRAME_CLKS);
        if (delay_mod == '0) begin
            start_pos = '0;
        end else begin
            start_pos = OFF_W'(FRAME_CLKS) - delay_mod;
        end
        load_pos_o = POS_W'(start_pos);
    end

endmodule

// File: rtl/hwy_rx_position.sv
`timescale 1ns/1ps
module hwy_rx_position #(
    parameter int FRAME_CLKS = 512,
    parameter int POS_W      = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_i,
    input  logic [POS_W-1:0] load_pos_i,
    output logic [POS_W-1:0] pos_o,
    output logic             locked_o
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_CLKS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             locked;
    } pos_state_t;

    pos_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fsync_i) begin
            st_d.pos    = load_pos_i;
            st_d.locked = 1'b1;
        end else if (st_q.pos == LAST_POS) begin
            st_d.pos = '0;
        end else begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o    = st_q.pos;
    assign locked_o = st_q.locked;

endmodule

// File: rtl/hwy_rx_bitpick.sv
`timescale 1ns/1ps
module hwy_rx_bitpick
    import hwy_rx_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int POS_W     = 9,
    parameter int SLOT_W    = 5
) (
    input  logic [POS_W-1:0]     pos_i,
    input  logic                 locked_i,
    input  logic                 rate_i,
    input  logic                 phase_sel_i,
    input  logic [SLOT_BITS-1:0] byte_i,
    output logic [SLOT_W-1:0]    slot_o,
    output hwy_out_t             next_o
);
    localparam int IDX_W = $clog2(SLOT_BITS);

    logic [IDX_W:0]   win_pos;
    logic [IDX_W-1:0] bit_idx;
    logic             in_phase;
    logic             sel_bit;
    hwy_rate_e        rate;

    always_comb begin
        rate    = hwy_rate_e'(rate_i);
        win_pos = pos_i[IDX_W:0];
        slot_o  = pos_i[POS_W-1:IDX_W+1];
        if (rate == RATE_SINGLE) begin
            bit_idx  = win_pos[IDX_W:1];
            in_phase = 1'b1;
        end else begin
            bit_idx  = win_pos[IDX_W-1:0];
            in_phase = (win_pos[IDX_W] == phase_sel_i);
        end
        sel_bit = byte_i[IDX_W'(SLOT_BITS - 1) - bit_idx];
        if (locked_i && in_phase) begin
            next_o = '{data: sel_bit, en: 1'b1};
        end else begin
            next_o = HWY_IDLE;
        end
    end

endmodule

// File: rtl/hwy_rx_driver.sv
`timescale 1ns/1ps
module hwy_rx_driver
    import hwy_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hwy_out_t next_i,
    output logic     data_o,
    output logic     oe_o
);
    hwy_out_t out_d, out_q;

    always_comb begin
        out_d = next_i;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= HWY_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    assign data_o = out_q.data;
    assign oe_o   = out_q.en;

endmodule

// File: rtl/hwy_rx_serializer.sv
`timescale 1ns/1ps
module hwy_rx_serializer
    import hwy_rx_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_BITS = 8,
    parameter int TS_W      = 6,
    parameter int CS_W      = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fsync_i,
    input  logic                        rate_i,
    input  logic                        phase_sel_i,
    input  logic [TS_W-1:0]             ts_off_i,
    input  logic [CS_W-1:0]             cs_off_i,
    input  logic                        half_sel_i,
    output logic [$clog2(NUM_SLOTS)-1:0] slot_idx_o,
    input  logic [SLOT_BITS-1:0]        slot_byte_i,
    output logic                        hwy_data_o,
    output logic                        hwy_oe_o
);
    localparam int CLK_PER_SLOT = 2 * SLOT_BITS;
    localparam int FRAME_CLKS   = NUM_SLOTS * CLK_PER_SLOT;
    localparam int POS_W        = $clog2(FRAME_CLKS);
    localparam int SLOT_W       = $clog2(NUM_SLOTS);

    logic [POS_W-1:0] load_pos;
    logic [POS_W-1:0] pos_q;
    logic             locked_q;
    hwy_out_t         next_out;

    hwy_rx_offset #(
        .TS_W(TS_W), .CS_W(CS_W), .CLK_PER_SLOT(CLK_PER_SLOT),
        .FRAME_CLKS(FRAME_CLKS), .POS_W(POS_W)
    ) u_offset (
        .ts_off_i(ts_off_i), .cs_off_i(cs_off_i), .half_sel_i(half_sel_i),
        .load_pos_o(load_pos)
    );

    hwy_rx_position #(
        .FRAME_CLKS(FRAME_CLKS), .POS_W(POS_W)
    ) u_position (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .load_pos_i(load_pos),
        .pos_o(pos_q), .locked_o(locked_q)
    );

    hwy_rx_bitpick #(
        .SLOT_BITS(SLOT_BITS), .POS_W(POS_W), .SLOT_W(SLOT_W)
    ) u_bitpick (
        .pos_i(pos_q), .locked_i(locked_q), .rate_i(rate_i),
        .phase_sel_i(phase_sel_i), .byte_i(slot_byte_i),
        .slot_o(slot_idx_o), .next_o(next_out)
    );

    hwy_rx_driver u_driver (
        .clk(clk), .rst_n(rst_n), .next_i(next_out),
        .data_o(hwy_data_o), .oe_o(hwy_oe_o)
    );

endmodule

// File: rtl/hwy_rx_serializer_chk.sv
`timescale 1ns/1ps
module hwy_rx_serializer_chk #(
    parameter int FRAME_CLKS   = 512,
    parameter int CLK_PER_SLOT = 16,
    parameter int POS_W        = 9,
    parameter int TS_W         = 6,
    parameter int CS_W         = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync_i,
    input logic [TS_W-1:0]  ts_off_i,
    input logic [CS_W-1:0]  cs_off_i,
    input logic             half_sel_i,
    input logic [POS_W-1:0] pos_q,
    input logic             locked_q,
    input logic             hwy_data_o,
    input logic             hwy_oe_o
);
    localparam int SUM_W = POS_W + TS_W + 6;
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_CLKS - 1);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !locked_q |-> (!hwy_oe_o && hwy_data_o));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_i && pos_q != LAST) |=> (pos_q == $past(pos_q) + 1'b1));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync_i && pos_q == LAST) |=> (pos_q == '0));

    // R5 and R11: position plus delay lands on a frame boundary after any sync
    p_sync_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_i |=> (((SUM_W'(pos_q)
                      + SUM_W'($past(ts_off_i)) * SUM_W'(CLK_PER_SLOT)
                      + SUM_W'($past(cs_off_i)) * SUM_W'(2)
                      + SUM_W'($past(half_sel_i))) % SUM_W'(FRAME_CLKS)) == '0));

    p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hwy_oe_o |-> hwy_data_o);

    p_oe_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hwy_oe_o |-> locked_q);

endmodule

bind hwy_rx_serializer hwy_rx_serializer_chk #(
    .FRAME_CLKS(FRAME_CLKS), .CLK_PER_SLOT(CLK_PER_SLOT),
    .POS_W(POS_W), .TS_W(TS_W), .CS_W(CS_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i),
    .ts_off_i(ts_off_i), .cs_off_i(cs_off_i), .half_sel_i(half_sel_i),
    .pos_q(pos_q), .locked_q(locked_q),
    .hwy_data_o(hwy_data_o), .hwy_oe_o(hwy_oe_o)
);

// File: tb/hwy_rx_serializer_bench.sv
`timescale 1ns/1ps
module hwy_rx_serializer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       rate = 1'b0;
    logic       phase_sel = 1'b0;
    logic [5:0] ts_off = '0;
    logic [2:0] cs_off = '0;
    logic       half_sel = 1'b0;
    logic [4:0] slot_idx;
    logic [7:0] slot_byte;
    logic       hwy_data;
    logic       hwy_oe;

    logic [7:0] mem [32];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign slot_byte = mem[slot_idx];

    hwy_rx_serializer u_hwy_rx_serializer (
        .clk(clk), .rst_n(rst_n), .fsync_i(fsync), .rate_i(rate),
        .phase_sel_i(phase_sel), .ts_off_i(ts_off), .cs_off_i(cs_off),
        .half_sel_i(half_sel), .slot_idx_o(slot_idx), .slot_byte_i(slot_byte),
        .hwy_data_o(hwy_data), .hwy_oe_o(hwy_oe)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic void model(int p, bit dbl, bit ph, output bit d, output bit e);
        int s, w;
        s = p / 16;
        w = p % 16;
        if (!dbl) begin
            e = 1'b1;
            d = mem[s][7 - w / 2];
        end else begin
            e = ((w / 8) == int'(ph));
            d = e ? mem[s][7 - w % 8] : 1'b1;
        end
    endfunction

    task automatic t_reset_idle();
        int bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #2;
            if (hwy_oe !== 1'b0 || hwy_data !== 1'b1) bad++;
        end
        check("R1", "idle mismatches before first sync", bad, 0);
    endtask

    // Sync with given settings, then compare nsamp clocks; chg_at flips ts_off
    task automatic t_run(string name, bit dbl, bit ph, int ts, int cs, bit hs,
                         int nsamp, int chg_at, string dtag, string otag);
        int off;
        int bad_d = 0, bad_e = 0, bad_s = 0, bad_st = 0;
        int fk_d = -1, fa_d = 0, fe_d = 0;
        int fk_e = -1, fa_e = 0, fe_e = 0;
        int fa_s = 0, fe_s = 0;
        @(negedge clk);
        rate = dbl; phase_sel = ph;
        ts_off = 6'(ts); cs_off = 3'(cs); half_sel = hs;
        @(negedge clk);
        fsync = 1'b1;
        @(negedge clk);
        fsync = 1'b0;
        off = (ts * 16 + cs * 2 + int'(hs)) % 512;
        for (int k = 0; k < nsamp; k++) begin
            int p;
            bit ed, ee, sd, se;
            if (k > 0) @(negedge clk);
            if (k == chg_at) ts_off = ts_off ^ 6'h15;
            #2;
            p = ((k - off) % 512 + 512) % 512;
            model(p, dbl, ph, ed, ee);
            if (int'(slot_idx) != p / 16) begin
                if (bad_s == 0) begin fa_s = int'(slot_idx); fe_s = p / 16; end
                bad_s++;
            end
            if (hwy_data !== ed) begin
                if (bad_d == 0) begin fk_d = k; fa_d = int'(hwy_data); fe_d = int'(ed); end
                bad_d++;
            end
            if (hwy_oe !== ee) begin
                if (bad_e == 0) begin fk_e = k; fa_e = int'(hwy_oe); fe_e = int'(ee); end
                bad_e++;
            end
            sd = hwy_data; se = hwy_oe;
            @(posedge clk); #1;
            if (hwy_data !== sd || hwy_oe !== se) bad_st++;
        end
        check(dtag, $sformatf("%s data (first bad clock %0d, bit act=%0d exp=%0d), mismatches",
              name, fk_d, fa_d, fe_d), bad_d, 0);
        check(otag, $sformatf("%s enable (first bad clock %0d, act=%0d exp=%0d), mismatches",
              name, fk_e, fa_e, fe_e), bad_e, 0);
        check("R2", $sformatf("%s slot index (first act=%0d exp=%0d), mismatches",
              name, fa_s, fe_s), bad_s, 0);
        check("R4", $sformatf("%s changes at rising edge", name), bad_st, 0);
    endtask

    initial begin
        for (int s = 0; s < 32; s++) mem[s] = 8'((s * 37 + 90) ^ (s << 3));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();                                              // R1
        t_run("single zero offset, two frames", 1'b0, 1'b0, 0, 0, 1'b0,
              1030, -1, "R3", "R3");                                 // R3 R9
        t_run("single mixed offset", 1'b0, 1'b0, 5, 3, 1'b1,
              600, -1, "R5", "R3");                                  // R5 R11
        t_run("double phase0", 1'b1, 1'b0, 2, 1, 1'b0,
              600, -1, "R6", "R7");                                  // R6 R7
        t_run("double phase1 wrapped offset", 1'b1, 1'b1, 40, 7, 1'b1,
              700, -1, "R8", "R7");                                  // R8 R11
        t_run("offset change ignored", 1'b0, 1'b0, 9, 2, 1'b0,
              700, 100, "R10", "R10");                               // R10
        t_run("double phase1 frame wrap", 1'b1, 1'b1, 0, 0, 1'b0,
              1030, -1, "R9", "R9");                                 // R9
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1200000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule